// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of a multi-function peripheral chip. It sits on a legacy host byte bus with an address, a write strobe, a read strobe and 8-bit data. It answers at two byte addresses: an index port at `CFG_BASE` and a data port at `CFG_BASE+1`. The block comes out of reset locked in run state. In run state, reads of either port return 0xFF and writes to the data port are ignored. Writing the unlock byte 0x55 to the index port opens configuration state. Writing 0xAA to the index port closes it again.

In configuration state, the host first writes a register index to the index port and then reads or writes the data port. A few indexes are global: the logical device number, the chip ID and the revision. The other indexes go to the bank of the logical device that the device-number register selects. Each bank holds an activate bit, a primary and a secondary 16-bit base address, and a primary and a secondary interrupt select. Devices 1 and 2 are disk interfaces, 3 is parallel, 4 and 5 are serial ports, 7 is the keyboard and 8 is the auxiliary I/O bank. The settings of every bank are driven out continuously, so that the peripheral functions can decode their own I/O ranges and route their interrupts.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the block is in run state (`cfg_mode`=0), the index register and the logical device number are 0, and every activate bit, base address and interrupt select is 0.
- R2: In run state, a write of exactly 0x55 to the index port enters configuration state. Any other byte written there leaves the block in run state.
- R3: In configuration state, a write of 0xAA to the index port returns the block to run state. Any other byte written there becomes the current index.
- R4: In run state, reads of the index port or the data port return 0xFF, and data-port writes change no register.
- R5: In configuration state, an index-port read returns the current index. Index 0x07 is the read/write logical device number (8 bits).
- R6: Index 0x20 reads 0x30 and index 0x21 reads 0x01. Writes to these indexes have no effect.
- R7: Index 0x30 holds the activate bit of the selected device in data bit 0, and the other data bits read 0. Device n's activate bit appears on `dev_active[n]`.
- R8: Indexes 0x60 and 0x61 hold the high and low bytes of the primary base, and 0x62 and 0x63 hold the high and low bytes of the secondary base. Device n's primary base appears on `dev_base_pri[16n+15:16n]` and its secondary base on `dev_base_sec[16n+15:16n]`.
- R9: Index 0x70 holds the primary interrupt select and index 0x72 the secondary one. Device n's selects appear on `dev_irq_pri[8n+7:8n]` and `dev_irq_sec[8n+7:8n]`.
- R10: A bank write changes only the bank of the selected device. When the device number is NDEV (9) or higher, bank writes are ignored and bank indexes read 0x00.
- R11: In configuration state, data-port reads of unimplemented indexes return 0x00. Reads at addresses other than the two ports return 0x00, and writes there are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 16 | Host I/O address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational, 0 when no read is in progress |
| cfg_mode | output | 1 | 1 in configuration state |
| dev_active | output | NDEV | Activate bit per device |
| dev_base_pri | output | 16*NDEV | Primary base address per device |
| dev_base_sec | output | 16*NDEV | Secondary base address per device |
| dev_irq_pri | output | 8*NDEV | Primary interrupt select per device |
| dev_irq_sec | output | 8*NDEV | Secondary interrupt select per device |

## Verification
The assertions watch the lock on every cycle. A non-key byte written in run state never unlocks the block, the exit key always relocks it, and run-state reads return 0xFF. They also check that data-port writes in run state leave the device number and activate bits unchanged, that at most one activate bit changes per cycle, and that ID reads are correct. Other behaviours can only be shown by the bench's sweeps: the bank isolation across all nine devices and the out-of-range device numbers, the readback of every index for every bank, and the mapping of each bank onto the exported port slices.

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port #(
  parameter logic [15:0] CFG_BASE  = 16'h03F0,
  parameter int          NDEV      = 9,
  parameter logic [7:0]  ENTER_KEY = 8'h55,
  parameter logic [7:0]  EXIT_KEY  = 8'hAA,
  parameter logic [7:0]  CHIP_ID   = 8'h30,
  parameter logic [7:0]  CHIP_REV  = 8'h01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          host_addr,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  output logic                 cfg_mode,
  output logic [NDEV-1:0]      dev_active,
  output logic [NDEV*16-1:0]   dev_base_pri,
  output logic [NDEV*16-1:0]   dev_base_sec,
  output logic [NDEV*8-1:0]    dev_irq_pri,
  output logic [NDEV*8-1:0]    dev_irq_sec
);
  localparam int         LW     = $clog2(NDEV);
  localparam logic [7:0] NDEV_B = 8'(NDEV);

  logic       cfg_q;
  logic [7:0] idx_q, ldn_q;
  logic       act_q [NDEV];
  logic [15:0] bp_q [NDEV];
  logic [15:0] bs_q [NDEV];
  logic [7:0]  ip_q [NDEV];
  logic [7:0]  is_q [NDEV];

  wire          hit_idx = host_addr == CFG_BASE;
  wire          hit_dat = host_addr == CFG_BASE + 16'd1;
  wire          dat_we  = host_wr && hit_dat && cfg_q;
  wire          sel_ok  = ldn_q < NDEV_B;
  wire [LW-1:0] sel     = ldn_q[LW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= 1'b0;
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (host_wr && hit_idx) begin
        if (!cfg_q)                      cfg_q <= host_wdata == ENTER_KEY;
        else if (host_wdata == EXIT_KEY) cfg_q <= 1'b0;
        else                             idx_q <= host_wdata;
      end
      if (dat_we && idx_q == 8'h07) ldn_q <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NDEV; d++) begin
        act_q[d] <= 1'b0;
        bp_q[d]  <= 16'h0000;
        bs_q[d]  <= 16'h0000;
        ip_q[d]  <= 8'h00;
        is_q[d]  <= 8'h00;
      end
    end else if (dat_we && sel_ok) begin
      for (int d = 0; d < NDEV; d++) begin
        if (sel == LW'(d)) begin
          case (idx_q)
            8'h30: act_q[d]      <= host_wdata[0];
            8'h60: bp_q[d][15:8] <= host_wdata;
            8'h61: bp_q[d][7:0]  <= host_wdata;
            8'h62: bs_q[d][15:8] <= host_wdata;
            8'h63: bs_q[d][7:0]  <= host_wdata;
            8'h70: ip_q[d]       <= host_wdata;
            8'h72: is_q[d]       <= host_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  logic [7:0] reg_val;
  always_comb begin
    reg_val = 8'h00;
    case (idx_q)
      8'h07: reg_val = ldn_q;
      8'h20: reg_val = CHIP_ID;
      8'h21: reg_val = CHIP_REV;
      default: ;
    endcase
    if (sel_ok) begin
      case (idx_q)
        8'h30: reg_val = {7'b0, act_q[sel]};
        8'h60: reg_val = bp_q[sel][15:8];
        8'h61: reg_val = bp_q[sel][7:0];
        8'h62: reg_val = bs_q[sel][15:8];
        8'h63: reg_val = bs_q[sel][7:0];
        8'h70: reg_val = ip_q[sel];
        8'h72: reg_val = is_q[sel];
        default: ;
      endcase
    end
  end

  assign host_rdata = !host_rd ? 8'h00 :
                      hit_idx  ? (cfg_q ? idx_q   : 8'hFF) :
                      hit_dat  ? (cfg_q ? reg_val : 8'hFF) : 8'h00;
  assign cfg_mode = cfg_q;

  for (genvar g = 0; g < NDEV; g++) begin : g_out
    assign dev_active[g]            = act_q[g];
    assign dev_base_pri[g*16 +: 16] = bp_q[g];
    assign dev_base_sec[g*16 +: 16] = bs_q[g];
    assign dev_irq_pri[g*8 +: 8]    = ip_q[g];
    assign dev_irq_sec[g*8 +: 8]    = is_q[g];
  end

  assert_lock_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && host_wr && hit_idx && host_wdata != ENTER_KEY) |=> !cfg_mode);
  assert_exit_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && host_wr && hit_idx && host_wdata == EXIT_KEY) |=> !cfg_mode);
  assert_run_reads_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && host_rd && (hit_idx || hit_dat)) |-> host_rdata == 8'hFF);
  assert_run_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && host_wr && hit_dat) |=> ($stable(dev_active) && $stable(ldn_q)));
  assert_chip_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && host_rd && hit_dat && idx_q == 8'h20) |-> host_rdata == CHIP_ID);
  assert_one_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(dev_active ^ $past(dev_active)) <= 1);
endmodule

// File: tb/keyed_cfg_port_tb_top.sv
module keyed_cfg_port_tb_top;
  localparam int ND = 9;
  localparam logic [15:0] IDXP = 16'h03F0;
  localparam logic [15:0] DATP = 16'h03F1;

  logic clk = 0, rst_n = 0;
  logic [15:0] host_addr = 0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic cfg_mode;
  logic [ND-1:0] dev_active;
  logic [ND*16-1:0] dev_base_pri, dev_base_sec;
  logic [ND*8-1:0] dev_irq_pri, dev_irq_sec;

  keyed_cfg_port dut_i (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic       e_act [ND];
  logic [15:0] e_bp [ND], e_bs [ND];
  logic [7:0]  e_ip [ND], e_is [ND];

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0; host_addr = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 0; host_addr = 0;
  endtask

  function automatic logic [7:0] exp_read(logic [7:0] i, logic [7:0] dv);
    case (i)
      8'h07: return dv;
      8'h20: return 8'h30;
      8'h21: return 8'h01;
      default: ;
    endcase
    if (dv >= ND) return 8'h00;
    case (i)
      8'h30: return {7'b0, e_act[dv]};
      8'h60: return e_bp[dv][15:8];
      8'h61: return e_bp[dv][7:0];
      8'h62: return e_bs[dv][15:8];
      8'h63: return e_bs[dv][7:0];
      8'h70: return e_ip[dv];
      8'h72: return e_is[dv];
      default: return 8'h00;
    endcase
  endfunction

  task automatic put(logic [7:0] i, logic [7:0] d);
    wr(IDXP, i); wr(DATP, d);
  endtask

  task automatic check_ports(string req);
    for (int d = 0; d < ND; d++) begin
      check({req, " R7 active"}, dev_active[d], e_act[d]);
      check({req, " R8 base pri"}, dev_base_pri[d*16 +: 16], e_bp[d]);
      check({req, " R8 base sec"}, dev_base_sec[d*16 +: 16], e_bs[d]);
      check({req, " R9 irq pri"}, dev_irq_pri[d*8 +: 8], e_ip[d]);
      check({req, " R9 irq sec"}, dev_irq_sec[d*8 +: 8], e_is[d]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int d = 0; d < ND; d++) begin
      e_act[d] = 0; e_bp[d] = 0; e_bs[d] = 0; e_ip[d] = 0; e_is[d] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 run state", cfg_mode, 0);
    check_ports("R1 reset");

    for (int b = 0; b < 256; b++) begin
      if (b == 8'h55) continue;
      wr(IDXP, 8'(b));
      check("R2 lock holds", cfg_mode, 0);
    end
    rd(DATP, v); check("R4 run data read", v, 8'hFF);
    rd(IDXP, v); check("R4 run index read", v, 8'hFF);
    wr(DATP, 8'h07);
    check_ports("R4 run write");

    wr(IDXP, 8'h55);
    check("R2 unlock", cfg_mode, 1);
    rd(IDXP, v); check("R5 index read after unlock", v, 8'h00);

    wr(IDXP, 8'h20); rd(DATP, v); check("R6 id", v, 8'h30);
    wr(DATP, 8'hFF); rd(DATP, v); check("R6 id read-only", v, 8'h30);
    wr(IDXP, 8'h21); rd(DATP, v); check("R6 rev", v, 8'h01);

    for (int d = 0; d < ND; d++) begin
      put(8'h07, 8'(d));
      rd(DATP, v); check("R5 ldn readback", v, d);
      e_act[d] = (d % 3) != 0;
      e_bp[d]  = 16'h01F0 + 16'(d) * 16'h0101;
      e_bs[d]  = 16'h03F6 ^ (16'(d) << 4);
      e_ip[d]  = 8'(d + 3);
      e_is[d]  = 8'hC0 | 8'(d);
      put(8'h30, {7'h7F, e_act[d]});
      put(8'h60, e_bp[d][15:8]); put(8'h61, e_bp[d][7:0]);
      put(8'h62, e_bs[d][15:8]); put(8'h63, e_bs[d][7:0]);
      put(8'h70, e_ip[d]);       put(8'h72, e_is[d]);
      put(8'h71, 8'h5A);
      check_ports("R10 bank isolation");
    end

    foreach (v[k]) ;
    put(8'h07, 8'd9);
    put(8'h30, 8'h01); put(8'h60, 8'hEE); put(8'h70, 8'h77);
    put(8'h07, 8'd200);
    put(8'h62, 8'hEE); put(8'h72, 8'h77);
    check_ports("R10 out-of-range ignored");

    for (int s = 0; s <= ND; s++) begin
      logic [7:0] dv;
      dv = (s == ND) ? 8'd200 : 8'(s);
      put(8'h07, dv);
      for (int i = 0; i < 256; i++) begin
        if (i == 8'hAA) continue;
        wr(IDXP, 8'(i));
        rd(DATP, v);
        check("R11 index sweep", v, exp_read(8'(i), dv));
      end
      rd(IDXP, v); check("R5 index port read", v, 8'hFF);
    end

    put(8'h07, 8'd1);
    wr(IDXP, 8'h30);
    wr(IDXP, 8'hAA);
    check("R3 exit", cfg_mode, 0);
    rd(DATP, v); check("R4 run read after exit", v, 8'hFF);
    wr(DATP, 8'h00);
    wr(IDXP, 8'h60);
    check_ports("R4 run write ignored");
    wr(IDXP, 8'h55);
    check("R2 re-enter", cfg_mode, 1);
    rd(DATP, v); check("R3 index kept", v, {7'b0, e_act[1]});

    wr(16'h0060, 8'h33);
    rd(16'h0060, v); check("R11 other address read", v, 8'h00);
    check_ports("R11 other address write");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule